// File: doc/BRIEF.md
# Shift and Rotate Unit

A purely combinational unit that moves the bits of an 8-bit or 16-bit operand left or right. It covers plain rotates, rotates that pass through the carry bit, logical shifts and the arithmetic right shift. It produces the new operand value and five status flags: carry, overflow, sign, zero and parity. Next to the flags it drives a valid mask, and each set bit in that mask tells the surrounding execution logic which flags the operation writes. Flags whose valid bit is clear must be left at their old values by the consumer.

The count is an 8-bit value and is used in full, without masking, so large counts behave like a long sequence of single-bit steps. A width select chooses the active operand width. In narrow mode the upper byte of the operand is ignored and the upper byte of the result is zero. Operand fetch, result writeback and any cycle-level timing belong to the caller.

Top module: `shift_rotate_unit`

## Requirements
- R1: When `count` is 0, `result` equals the operand restricted to the active width (upper byte zero in narrow mode), and `flagValid` and `flagOut` are both all zero.
- R2: Operation code 0 rotates left and code 1 rotates right within the active width n. Carry is the last bit moved across the end. For a rotate left this is result bit 0; for a rotate right it is result bit n-1. Any count, including multiples of n, equals that many single-bit steps.
- R3: Code 2 (rotate left through carry) and code 3 (rotate right through carry) rotate the (n+1)-bit value {carryIn, operand}. The low n bits become the result and the bit left in position n becomes the carry.
- R4: Code 4 shifts left and code 5 shifts right, filling with zeros. Carry is the last bit shifted out. The full 8-bit count is used, so any count of n+1 or more gives a zero result and a zero carry.
- R5: Code 7 shifts right arithmetically, copying the sign bit (bit n-1) into the vacated positions. Counts of n or more give a result of all sign bits and a carry equal to the sign bit.
- R6: The flag bit positions are carry 0, parity 1, zero 2, sign 3, overflow 4. For a nonzero count, rotates (codes 0 to 3) mark only carry valid, and shifts (codes 4, 5, 7) mark carry, parity, zero and sign valid. Overflow is marked valid only when the count is exactly 1.
- R7: With a count of 1, overflow for a left operation (codes 0, 2, 4) is the carry out XOR result bit n-1. For a right operation (codes 1, 3, 5, 7) it is result bit n-1 XOR result bit n-2.
- R8: Sign is result bit n-1. Zero is set when the active-width result is 0. Parity is set when result bits 7:0 contain an even number of ones.
- R9: Every `flagOut` bit whose `flagValid` bit is clear is driven 0.
- R10: With `wideSel` = 0 (8-bit mode), operand bits 15:8 have no effect and result bits 15:8 are 0. With `wideSel` = 1, all 16 bits are active.
- R11: Operation code 6 is a no-operation and behaves exactly as a zero count (R1), whatever the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd | input | 16 | Operand; only bits 7:0 are used in 8-bit mode |
| carryIn | input | 1 | Incoming carry flag, used by the rotate-through-carry codes |
| opSel | input | 3 | Operation code (0 rotl, 1 rotr, 2 rotl via carry, 3 rotr via carry, 4 shl, 5 shr, 6 none, 7 sar) |
| count | input | 8 | Number of bit positions, used in full |
| wideSel | input | 1 | 1 selects 16-bit width, 0 selects 8-bit width |
| result | output | 16 | Shifted or rotated value |
| flagOut | output | 5 | Flag values {overflow, sign, zero, parity, carry} |
| flagValid | output | 5 | Per-flag update mask, same bit order as flagOut |

## Verification
The hardest cases to reach are the count boundaries around the active width. These are counts of n, n+1 and multiples of n+1 for the rotates through carry. They also include counts well beyond 32, where a masked count would give a different answer from the full 8-bit count. Uniform random counts seldom land on those values. The stimulus therefore sweeps every count from 0 to 40 and 255 for every operation and both widths, with random operands and carry. A random phase follows that weights small counts and puts random garbage in the unused upper byte for narrow-mode runs.

// File: rtl/srt_pkg.sv
package srt_pkg;

  typedef enum logic [2:0] {
    OP_ROTL  = 3'd0,
    OP_ROTR  = 3'd1,
    OP_RCRL  = 3'd2,
    OP_RCRR  = 3'd3,
    OP_SHLL  = 3'd4,
    OP_SHRL  = 3'd5,
    OP_NONE  = 3'd6,
    OP_SHRA  = 3'd7
  } srtOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic active;     // nonzero count and a real operation
    logic rotate;     // rotate family
    logic thruCarry;  // rotation spans width+1 bits
    logic toRight;    // direction
    logic arith;      // sign fill on right shift
    logic single;     // count equals one
  } srtCtrl_t;

  localparam int FLAG_C = 0;
  localparam int FLAG_P = 1;
  localparam int FLAG_Z = 2;
  localparam int FLAG_S = 3;
  localparam int FLAG_O = 4;
  localparam int FLAG_N = 5;

endpackage

// File: rtl/srt_ctrl.sv
module srt_ctrl
  import srt_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic [2:0]       opSel,
  input  logic [CNT_W-1:0] count,
  output srtCtrl_t         strobes
);

  srtOp_e opCode;

  always_comb begin
    opCode            = srtOp_e'(opSel);
    strobes           = '0;
    strobes.active    = (opCode != OP_NONE) && (count != '0);
    strobes.single    = (count == CNT_W'(1));
    case (opCode)
      OP_ROTL: begin strobes.rotate = 1'b1; end
      OP_ROTR: begin strobes.rotate = 1'b1; strobes.toRight = 1'b1; end
      OP_RCRL: begin strobes.rotate = 1'b1; strobes.thruCarry = 1'b1; end
      OP_RCRR: begin
        strobes.rotate    = 1'b1;
        strobes.thruCarry = 1'b1;
        strobes.toRight   = 1'b1;
      end
      OP_SHRL: begin strobes.toRight = 1'b1; end
      OP_SHRA: begin strobes.toRight = 1'b1; strobes.arith = 1'b1; end
      default: begin end
    endcase
  end

endmodule

// File: rtl/srt_path.sv
module srt_path
  import srt_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NARROW_W = 8,
  parameter int CNT_W    = 8
) (
  input  logic [DATA_W-1:0] opnd,
  input  logic              carryIn,
  input  logic              wideSel,
  input  logic [CNT_W-1:0]  count,
  input  srtCtrl_t          strobes,
  output logic [DATA_W-1:0] result,
  output logic [FLAG_N-1:0] flagOut,
  output logic [FLAG_N-1:0] flagValid
);

  localparam int XW = 2 * DATA_W + 2;
  localparam logic [XW-1:0] ONE = XW'(1);

  int          nW, mW, rotMod, rotAmt, shAmt, cntI;
  logic [XW-1:0] maskN, maskM, base, extV, rotV, leftV, rightSrc, rightV, resV;
  logic          signBit, fillOnes, carryV, msbV, nextV, ovV;
  logic [FLAG_N-1:0] rawFlags;

  always_comb begin
    cntI   = int'(count);
    nW     = wideSel ? DATA_W : NARROW_W;
    mW     = strobes.thruCarry ? nW + 1 : nW;
    maskN  = (ONE << nW) - ONE;
    maskM  = (ONE << mW) - ONE;
    base   = XW'(opnd) & maskN;
    signBit = base[nW-1];

    // rotate path: left rotation over mW bits
    extV   = base | ((strobes.thruCarry && carryIn) ? (ONE << nW) : '0);
    rotMod = cntI % mW;
    rotAmt = (strobes.toRight && rotMod != 0) ? mW - rotMod : rotMod;
    rotV   = ((extV << rotAmt) | (extV >> (mW - rotAmt))) & maskM;

    // shift path: count clipped to width+1
    shAmt    = (cntI > nW) ? nW + 1 : cntI;
    fillOnes = strobes.arith & signBit;
    leftV    = base << shAmt;
    rightSrc = (base | (fillOnes ? ~maskN : '0)) << 1;
    rightV   = fillOnes ? XW'($signed(rightSrc) >>> shAmt) : (rightSrc >> shAmt);
  end

  always_comb begin
    resV   = base;
    carryV = 1'b0;
    if (strobes.active) begin
      if (strobes.rotate) begin
        resV = rotV & maskN;
        if (strobes.thruCarry)    carryV = rotV[nW];
        else if (strobes.toRight) carryV = rotV[nW-1];
        else                      carryV = rotV[0];
      end else if (!strobes.toRight) begin
        resV   = leftV & maskN;
        carryV = leftV[nW];
      end else begin
        resV   = (rightV >> 1) & maskN;
        carryV = rightV[0];
      end
    end
  end

  always_comb begin
    msbV  = resV[nW-1];
    nextV = resV[nW-2];
    ovV   = strobes.toRight ? (msbV ^ nextV) : (carryV ^ msbV);

    rawFlags         = '0;
    rawFlags[FLAG_C] = carryV;
    rawFlags[FLAG_P] = ~^resV[7:0];
    rawFlags[FLAG_Z] = (resV == '0);
    rawFlags[FLAG_S] = msbV;
    rawFlags[FLAG_O] = ovV;

    flagValid         = '0;
    flagValid[FLAG_C] = strobes.active;
    flagValid[FLAG_O] = strobes.active & strobes.single;
    flagValid[FLAG_P] = strobes.active & ~strobes.rotate;
    flagValid[FLAG_Z] = strobes.active & ~strobes.rotate;
    flagValid[FLAG_S] = strobes.active & ~strobes.rotate;

    flagOut = rawFlags & flagValid;
    result  = resV[DATA_W-1:0];
  end

endmodule

// File: rtl/shift_rotate_unit.sv
module shift_rotate_unit
  import srt_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NARROW_W = 8,
  parameter int CNT_W    = 8
) (
  input  logic [DATA_W-1:0] opnd,
  input  logic              carryIn,
  input  logic [2:0]        opSel,
  input  logic [CNT_W-1:0]  count,
  input  logic              wideSel,
  output logic [DATA_W-1:0] result,
  output logic [FLAG_N-1:0] flagOut,
  output logic [FLAG_N-1:0] flagValid
);

  srtCtrl_t ctrlStrobes;

  srt_ctrl #(.CNT_W(CNT_W)) uCtrl (
    .opSel   (opSel),
    .count   (count),
    .strobes (ctrlStrobes)
  );

  srt_path #(.DATA_W(DATA_W), .NARROW_W(NARROW_W), .CNT_W(CNT_W)) uPath (
    .opnd      (opnd),
    .carryIn   (carryIn),
    .wideSel   (wideSel),
    .count     (count),
    .strobes   (ctrlStrobes),
    .result    (result),
    .flagOut   (flagOut),
    .flagValid (flagValid)
  );

endmodule

// File: rtl/srt_chk.sv
module srt_chk
  import srt_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NARROW_W = 8,
  parameter int CNT_W    = 8
) (
  input logic [DATA_W-1:0] opnd,
  input logic [2:0]        opSel,
  input logic [CNT_W-1:0]  count,
  input logic              wideSel,
  input logic [DATA_W-1:0] result,
  input logic [FLAG_N-1:0] flagOut,
  input logic [FLAG_N-1:0] flagValid
);

  logic [DATA_W-1:0] actMask;
  assign actMask = wideSel ? '1 : DATA_W'((1 << NARROW_W) - 1);

  always_comb begin
    if (!$isunknown({opSel, count, wideSel, opnd})) begin
      // R1, R11: idle operation passes the operand through with no flag updates
      p_idle_pass_r1: assert (!((count == '0) || (opSel == 3'd6)) ||
                              (flagValid == '0 && result == (opnd & actMask)));
      // R6: rotates never mark sign, zero or parity
      p_rot_mask_r6: assert (!(opSel[2] == 1'b0) ||
                             (flagValid[FLAG_S] == 1'b0 && flagValid[FLAG_Z] == 1'b0 &&
                              flagValid[FLAG_P] == 1'b0));
      // R6: overflow is only reported for a single-step count
      p_ov_single_r6: assert (!flagValid[FLAG_O] || count == CNT_W'(1));
      // R9: flags outside the mask read zero
      p_masked_zero_r9: assert ((flagOut & ~flagValid) == '0);
      // R10: narrow mode clears the upper result byte
      p_narrow_upper_r10: assert (wideSel || (result & ~actMask) == '0);
      // R8: zero flag agrees with the result when reported
      p_zero_flag_r8: assert (!flagValid[FLAG_Z] || flagOut[FLAG_Z] == (result == '0));
      // R8: parity flag agrees with the low byte when reported
      p_parity_r8: assert (!flagValid[FLAG_P] || flagOut[FLAG_P] == ~^result[7:0]);
    end
  end

endmodule

bind shift_rotate_unit srt_chk #(.DATA_W(DATA_W), .NARROW_W(NARROW_W), .CNT_W(CNT_W)) uChk (
  .opnd      (opnd),
  .opSel     (opSel),
  .count     (count),
  .wideSel   (wideSel),
  .result    (result),
  .flagOut   (flagOut),
  .flagValid (flagValid)
);

// File: tb/tb_shift_rotate_unit.sv
`timescale 1ns/1ps
module tb_shift_rotate_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] opnd = '0;
  logic        carryIn = 1'b0;
  logic [2:0]  opSel = '0;
  logic [7:0]  count = '0;
  logic        wideSel = 1'b0;
  logic [15:0] result;
  logic [4:0]  flagOut, flagValid;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  shift_rotate_unit dut (
    .opnd(opnd), .carryIn(carryIn), .opSel(opSel), .count(count),
    .wideSel(wideSel), .result(result), .flagOut(flagOut), .flagValid(flagValid)
  );

  // behavioural reference: step one bit at a time
  function automatic void refModel(input logic [15:0] a, input logic ci, input logic [2:0] op,
                                   input logic [7:0] cnt, input logic wd,
                                   output logic [15:0] r, output logic [4:0] fo,
                                   output logic [4:0] fv);
    int n = wd ? 16 : 8;
    int mask = (1 << n) - 1;
    int msb = 1 << (n - 1);
    int v = int'(a) & mask;
    int cf = int'(ci);
    int nc, ones;
    logic [4:0] raw;
    if (cnt == 0 || op == 3'd6) begin
      r = 16'(v); fo = '0; fv = '0; return;
    end
    for (int i = 0; i < int'(cnt); i++) begin
      case (op)
        3'd0: begin cf = (v & msb) != 0 ? 1 : 0; v = ((v << 1) | cf) & mask; end
        3'd1: begin cf = v & 1; v = (v >> 1) | (cf != 0 ? msb : 0); end
        3'd2: begin nc = (v & msb) != 0 ? 1 : 0; v = ((v << 1) | cf) & mask; cf = nc; end
        3'd3: begin nc = v & 1; v = (v >> 1) | (cf != 0 ? msb : 0); cf = nc; end
        3'd4: begin cf = (v & msb) != 0 ? 1 : 0; v = (v << 1) & mask; end
        3'd5: begin cf = v & 1; v = v >> 1; end
        default: begin cf = v & 1; v = (v >> 1) | (v & msb); end
      endcase
    end
    fv = 5'b00001;
    if (cnt == 1) fv[4] = 1'b1;
    if (op[2]) fv[3:1] = 3'b111;
    ones = 0;
    for (int b = 0; b < 8; b++) ones += (v >> b) & 1;
    raw[0] = cf[0];
    raw[1] = (ones % 2) == 0;
    raw[2] = v == 0;
    raw[3] = (v & msb) != 0;
    if (op == 3'd0 || op == 3'd2 || op == 3'd4)
      raw[4] = cf[0] ^ ((v & msb) != 0);
    else
      raw[4] = ((v >> (n - 1)) & 1) != ((v >> (n - 2)) & 1);
    r = 16'(v);
    fo = raw & fv;
  endfunction

  function automatic string reqOf(input logic [2:0] op, input logic [7:0] cnt);
    if (op == 3'd6) return "R11";
    if (cnt == 0) return "R1";
    case (op)
      3'd0, 3'd1: return "R2";
      3'd2, 3'd3: return "R3";
      3'd4, 3'd5: return "R4";
      default:    return "R5";
    endcase
  endfunction

  task automatic checkVal(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h (op=%0d cnt=%0d wide=%0d opnd=%h ci=%0d)",
               req, what, act, exp, opSel, count, wideSel, opnd, carryIn);
    end
  endtask

  // compare on every clock; inputs change only on falling edges
  always @(posedge clk) begin
    logic [15:0] er;
    logic [4:0]  efo, efv;
    if (rst) begin
      if (!finished) begin
        checkVal("R1", "reset result", int'(result), 0);
        checkVal("R1", "reset valid", int'(flagValid), 0);
      end
    end else if (!finished) begin
      refModel(opnd, carryIn, opSel, count, wideSel, er, efo, efv);
      checkVal(reqOf(opSel, count), "result", int'(result), int'(er));
      if (!wideSel) checkVal("R10", "upper byte", int'(result[15:8]), 0);
      checkVal((count == 0 || opSel == 3'd6) ? "R1" : "R6", "valid mask",
               int'(flagValid), int'(efv));
      checkVal(count == 1 ? "R7" : "R8", "flags", int'(flagOut), int'(efo));
      checkVal("R9", "masked flags", int'(flagOut & ~flagValid), 0);
    end
  end

  task automatic drive(input logic [15:0] a, input logic ci, input logic [2:0] op,
                       input logic [7:0] c, input logic wd);
    @(negedge clk);
    opnd = a; carryIn = ci; opSel = op; count = c; wideSel = wd;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // directed corners: R2 full-width rotate, R4 count 32 not masked, R5 sign fill
    drive(16'h8001, 1'b0, 3'd0, 8'd16, 1'b1);
    drive(16'hFFFF, 1'b1, 3'd4, 8'd32, 1'b1);
    drive(16'h8000, 1'b0, 3'd7, 8'd200, 1'b1);
    drive(16'hAB80, 1'b1, 3'd3, 8'd9, 1'b0);
    drive(16'h0081, 1'b0, 3'd5, 8'd1, 1'b0);
    drive(16'h1234, 1'b1, 3'd6, 8'd5, 1'b1);
    // sweep counts for every operation and width
    for (int op = 0; op < 8; op++)
      for (int wd = 0; wd < 2; wd++)
        for (int c = 0; c <= 41; c++)
          drive(16'($urandom), 1'($urandom), 3'(op), (c == 41) ? 8'd255 : 8'(c), 1'(wd));
    // random phase, small counts favoured
    for (int k = 0; k < 3000; k++)
      drive(16'($urandom), 1'($urandom), 3'($urandom),
            ($urandom % 2) ? 8'($urandom % 4) : 8'($urandom), 1'($urandom));
    @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      failures++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule